// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 32 level-sensitive peripheral request lines and presents them to a processor as two interrupt outputs, a normal request (IRQ) and a fast request (FIQ), plus an idle-wake signal. Software enables each source with a mask bit and steers it to IRQ or FIQ with a routing bit. Pending state is not stored: it follows the input lines, so a source stays pending until the peripheral drops its line.

A table of priority slots holds one source number per slot, each with a valid flag. The lowest-numbered valid slot whose source is active and routed to a given output wins for that output. A read-only status word reports both winners with their valid flags, so a handler can fetch the source to serve with a single read.

Registers sit behind a synchronous port. Writes take effect on the clock edge while the write enable is high. Read data is combinational from the word address. The port uses word indices: index k corresponds to byte offset 4*k.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable, routing and control registers and every slot valid flag are zero. The status word at index 6 reads zero, and both interrupt outputs are low.
- R2: The enable register (index 1), routing register (index 2) and control register (index 5, bit 0 only, other bits read 0) read back what was written. Slot i sits at index 7+i: bit 31 is its valid flag and bits 4:0 hold its source number. All other slot bits read 0.
- R3: Index 4 reads the raw source lines. Index 0 reads raw AND enable AND NOT routing, and index 3 reads raw AND enable AND routing. A routing bit of 1 selects FIQ.
- R4: Writes to indices 0, 3, 4 and 6 and to any index above 7+NSLOT-1 change no register. Reads of unmapped indices return zero.
- R5: `irq_o` equals the OR of the index-0 value one clock earlier. `fiq_o` equals the OR of the index-3 value one clock earlier.
- R6: The IRQ winner is the source of the lowest-numbered valid slot whose source is set in the index-0 value. Status bit 31 is then 1 and bits 30:16 hold that source number.
- R7: Slots with a clear valid flag are skipped. When no valid slot matches, status bits 31:16 read zero, even while `irq_o` is high.
- R8: The FIQ winner uses the same scan over the index-3 value. Status bit 15 is its valid flag and bits 14:0 hold its source number.
- R9: With control bit 0 set, `wake_o` is the OR of raw AND enable. With it clear, `wake_o` is the OR of the raw lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level-sensitive request lines |
| addr_i | input | AW | Register word index |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Registered normal interrupt |
| fiq_o | output | 1 | Registered fast interrupt |
| wake_o | output | 1 | Idle-wake request |

## Verification
The IRQ and FIQ arbitrations run in the same cycle over one slot table and share the status word. A bug that lets one half disturb the other is most likely here. The bench routes one of two simultaneously active slotted sources to FIQ. It then checks that the whole status word carries both winners at once, each with its own valid flag, and that both outputs rise on the following edge. It also sets a pending source that has no valid slot while another source wins, to judge that skipped slots and the winner field do not interfere.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 32,
  parameter int AW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            wake_o
);
  localparam int SW        = $clog2(NSRC);
  localparam int SLOT_BASE = 7;

  logic [NSRC-1:0]  mask_q, lvl_q;
  logic             ctrl_q;
  logic [SW-1:0]    slot_src_q [NSLOT];
  logic [NSLOT-1:0] slot_vld_q;

  wire [NSRC-1:0] irq_pend = src_i & mask_q & ~lvl_q;
  wire [NSRC-1:0] fiq_pend = src_i & mask_q & lvl_q;

  logic          irq_hit, fiq_hit;
  logic [SW-1:0] irq_win, fiq_win;

  always_comb begin
    irq_hit = 1'b0; irq_win = '0;
    fiq_hit = 1'b0; fiq_win = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_vld_q[i] && irq_pend[slot_src_q[i]]) begin
        irq_hit = 1'b1; irq_win = slot_src_q[i];
      end
      if (slot_vld_q[i] && fiq_pend[slot_src_q[i]]) begin
        fiq_hit = 1'b1; fiq_win = slot_src_q[i];
      end
    end
  end

  wire [31:0] hp_word = {irq_hit, 15'(irq_win), fiq_hit, 15'(fiq_win)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      lvl_q  <= '0;
      ctrl_q <= 1'b0;
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
    end else begin
      irq_o <= |irq_pend;
      fiq_o <= |fiq_pend;
      if (we_i && addr_i == AW'(1)) mask_q <= wdata_i[NSRC-1:0];
      if (we_i && addr_i == AW'(2)) lvl_q  <= wdata_i[NSRC-1:0];
      if (we_i && addr_i == AW'(5)) ctrl_q <= wdata_i[0];
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld_q[g] <= 1'b0;
        slot_src_q[g] <= '0;
      end else if (we_i && addr_i == AW'(SLOT_BASE + g)) begin
        slot_vld_q[g] <= wdata_i[31];
        slot_src_q[g] <= wdata_i[SW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(0): rdata_o = 32'(irq_pend);
      AW'(1): rdata_o = 32'(mask_q);
      AW'(2): rdata_o = 32'(lvl_q);
      AW'(3): rdata_o = 32'(fiq_pend);
      AW'(4): rdata_o = 32'(src_i);
      AW'(5): rdata_o = {31'd0, ctrl_q};
      AW'(6): rdata_o = hp_word;
      default: begin
        for (int i = 0; i < NSLOT; i++)
          if (addr_i == AW'(SLOT_BASE + i))
            rdata_o = {slot_vld_q[i], 31'(slot_src_q[i])};
      end
    endcase
  end

  assign wake_o = ctrl_q ? |(src_i & mask_q) : |src_i;

  assert_winner_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |-> (src_i[irq_win] && mask_q[irq_win] && !lvl_q[irq_win]));
  assert_fiq_winner_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_hit |-> (src_i[fiq_win] && mask_q[fiq_win] && lvl_q[fiq_win]));
  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |=> irq_o);
  assert_fiq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_hit |=> fiq_o);
  assert_quiet_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |=> (!irq_o && !fiq_o));
  assert_wake_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q && wake_o) |-> (|(src_i & mask_q)));
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == AW'(1)) |=> (mask_q == $past(wdata_i[NSRC-1:0])));
endmodule

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, wake;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  prio_intc dut_i (.clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .wake_o(wake));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk); src = v; #1;
  endtask

  task automatic t_reset;
    rd(1, 0, "R1 mask"); rd(2, 0, "R1 routing"); rd(5, 0, "R1 control");
    rd(7, 0, "R1 slot0"); rd(38, 0, "R1 slot31"); rd(6, 0, "R1 status");
    chk("R1 irq_o", 32'(irq), 0); chk("R1 fiq_o", 32'(fiq), 0);
  endtask

  task automatic t_regs;
    wr(1, 32'hA5A5_00FF); rd(1, 32'hA5A5_00FF, "R2 mask readback");
    wr(2, 32'h0F0F_1234); rd(2, 32'h0F0F_1234, "R2 routing readback");
    wr(5, 32'hFFFF_FFFF); rd(5, 32'h1, "R2 control bit0 only");
    wr(7, 32'h8000_00FF); rd(7, 32'h8000_001F, "R2 slot0 fields");
    wr(38, 32'h7FFF_FFE3); rd(38, 32'h0000_0003, "R2 slot31 fields");
    wr(5, 0);
  endtask

  task automatic t_pending;
    wr(1, 32'h0000_FF00); wr(2, 32'h0000_3000);
    set_src(32'h0000_F0F0);
    rd(0, 32'h0000_C000, "R3 irq pending");
    rd(3, 32'h0000_3000, "R3 fiq pending");
    rd(4, 32'h0000_F0F0, "R3 raw");
  endtask

  task automatic t_outputs;
    @(negedge clk); #1;
    chk("R5 irq_o high", 32'(irq), 1); chk("R5 fiq_o high", 32'(fiq), 1);
    set_src(0);
    chk("R5 irq_o holds one cycle", 32'(irq), 1);
    @(negedge clk); #1;
    chk("R5 irq_o low", 32'(irq), 0); chk("R5 fiq_o low", 32'(fiq), 0);
  endtask

  task automatic t_ignored;
    set_src(32'h0000_F0F0);
    wr(0, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF); wr(50, 32'hFFFF_FFFF);
    rd(0, 32'h0000_C000, "R4 irq pending after write");
    rd(3, 32'h0000_3000, "R4 fiq pending after write");
    rd(4, 32'h0000_F0F0, "R4 raw after write");
    rd(1, 32'h0000_FF00, "R4 mask untouched");
    rd(6, 0, "R4 status untouched");
    rd(50, 0, "R4 unmapped reads zero");
  endtask

  task automatic t_arb;
    wr(1, 32'hFFFF_FFFF); wr(2, 0);
    wr(7, 32'h8000_0007); wr(8, 32'h8000_0003);
    wr(9, 32'h0000_0009); wr(10, 32'h8000_0009);
    set_src(32'h0000_0208);
    rd(6, 32'h8003_0000, "R6 slot1 wins over slot3");
    set_src(32'h0000_0288);
    rd(6, 32'h8007_0000, "R6 slot0 highest");
    set_src(32'h0000_0200);
    rd(6, 32'h8009_0000, "R7 invalid slot2 skipped");
    set_src(32'h0010_0000);
    rd(6, 0, "R7 no slot matches");
    @(negedge clk); #1;
    chk("R7 irq_o high with no winner", 32'(irq), 1);
  endtask

  task automatic t_fiq;
    wr(2, 32'h0000_0008);
    set_src(32'h0000_0208);
    rd(6, 32'h8009_8003, "R8 concurrent irq and fiq winners");
    @(negedge clk); #1;
    chk("R8 irq_o", 32'(irq), 1); chk("R8 fiq_o", 32'(fiq), 1);
  endtask

  task automatic t_wake;
    wr(5, 0); wr(1, 0); set_src(32'h0000_0020);
    chk("R9 raw wakes", 32'(wake), 1);
    wr(5, 1); #1;
    chk("R9 masked no wake", 32'(wake), 0);
    wr(1, 32'h0000_0020); #1;
    chk("R9 enabled wakes", 32'(wake), 1);
    set_src(0);
    chk("R9 idle", 32'(wake), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_regs(); t_pending(); t_outputs(); t_ignored();
    t_arb(); t_fiq(); t_wake();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule